// File: doc/BRIEF.md
# Four-Lane Skew-Absorbing Bit-Interleaving Multiplexer

The block takes four one-bit lanes. Each lane arrives with its own lane clock, which runs at the same frequency as the reference clock but at an arbitrary fixed phase. A small elastic store per lane re-times the lane into the reference domain. Each store has a write pointer on the lane clock and a read pointer on the reference clock, placed half the store apart at reset. Each reference cycle the four re-timed bits form one 4-bit word, lane 0 first. A serializer on a clock four times faster then shifts that word out as one serial stream at four times the lane rate.

An active-low self-test input replaces the lane data with a free-running pseudo-random bit sequence. The sequence leaves the block through the same word register and serializer. Each lane also has a sticky slip flag. The flag rises when that lane's read pointer meets its write pointer, as seen after synchronisation into the reference domain. Only reset clears it.

Top module: `lane_interleave_mux`

## Requirements
- R1: While `rst_n` is low, `word_o`, `ser_o` and `slip_o` are all 0.
- R2: In every data word, bit 3 of `word_o` carries lane 0, bit 2 lane 1, bit 1 lane 2 and bit 0 lane 3, so the earliest serial bit of each group comes from lane 0.
- R3: Each lane clock has the reference frequency and any fixed phase. Count edges from 0 after reset release. The bit a lane samples on its j-th rising lane-clock edge appears on `word_o` after the (j+5)-th rising `clk_ref` edge, which is half of the 10-entry store depth.
- R4: The words registered on the first five `clk_ref` edges after reset release (edges 0 to 4) are all zero.
- R5: `clk_ser` runs at four times the `clk_ref` rate. The serializer loads `word_o` on every fourth rising `clk_ser` edge after reset release (edges 3, 7, 11 and so on) and shifts it out on `ser_o` bit 3 first, one bit per `clk_ser` cycle.
- R6: When `test_n` is sampled low at a `clk_ref` edge, the registered word is the next four bits of the sequence from the polynomial x^7+x^6+1 (b[k] = b[k-6] xor b[k-7]), earliest bit in bit 3. In that case lane data has no effect. The generator is seeded all-ones at reset, advances four bits every reference cycle and never produces only zeros.
- R7: A lane's slip flag in `slip_o` (bit i for lane i) sets when that lane's read pointer equals its synchronised write pointer, for example when its lane clock stops for 10 or more reference cycles. Once set it stays set, and the other lanes' flags are not affected.
- R8: Only reset clears `slip_o`. With all lane clocks running at the reference frequency, no flag sets.
- R9: The write pointer crosses into the reference domain Gray-coded. Its synchronised value changes in at most one bit per reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; one word per cycle |
| clk_ser | input | 1 | Serial clock, four times `clk_ref`, phase-locked to it |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| test_n | input | 1 | Active-low self-test select |
| lane_clk | input | 4 | Per-lane clocks, bit i for lane i |
| lane_dat | input | 4 | Per-lane data, bit i for lane i |
| word_o | output | 4 | Interleaved word, lane 0 in bit 3 |
| ser_o | output | 1 | Serial output stream |
| slip_o | output | 4 | Sticky per-lane pointer-collision flags |

## Verification
The properties assume the following about the inputs:
- Every lane clock keeps the reference frequency, except during a deliberate stall.
- `clk_ser` is exactly four times `clk_ref`, with its rising edges offset from the reference edges.
- Reset is released, and `test_n` changes, away from any clock edge.

The bench meets these assumptions as follows:
- It derives each lane clock from a delay of the reference period, with a fixed offset of 1, 3, 6 or 9 ns.
- It releases reset 0.5 ns after a falling reference edge.
- It changes `test_n` and the clock gates only on falling reference edges.
- It drives lane data 2 ns after each lane edge.
- It stops a lane clock only in the slip scenario, which ends in a reset.

// File: rtl/ilm_pkg.sv
`timescale 1ns/1ps
package ilm_pkg;

    // Pseudo-random generator: x^7 + x^6 + 1, new bit enters at bit 0
    localparam int          PRBS_W    = 7;
    localparam logic [6:0]  PRBS_SEED = 7'h7F;

    function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
        return {s[PRBS_W-2:0], s[6] ^ s[5]};
    endfunction

endpackage

// File: rtl/ilm_estore.sv
`timescale 1ns/1ps
module ilm_estore #(
    parameter  int DEPTH = 10,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          din,
    output logic          dout,
    output logic          slip,
    output logic [PW-1:0] wsync
);
    // Counter walks OFF .. OFF+DEPTH-1 so that Gray codes wrap with one bit change
    localparam int          OFF    = ((1 << PW) - DEPTH) / 2;
    localparam logic [PW-1:0] LO   = PW'(OFF);
    localparam logic [PW-1:0] HI   = PW'(OFF + DEPTH - 1);
    localparam logic [PW-1:0] WRST = PW'(OFF + DEPTH / 2);

    function automatic logic [PW-1:0] gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] step(input logic [PW-1:0] c);
        return (c == HI) ? LO : c + PW'(1);
    endfunction

    typedef struct packed {
        logic [PW-1:0]    cnt;
        logic [PW-1:0]    gry;
        logic [DEPTH-1:0] mem;
    } wr_t;

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [PW-1:0] s1;
        logic [PW-1:0] s2;
        logic          slip;
    } rd_t;

    wr_t wr_d, wr_q;
    rd_t rd_d, rd_q;
    logic [PW-1:0] waddr, raddr;

    // ---------------- write side (lane clock) ----------------
    always_comb begin
        wr_d        = wr_q;
        waddr       = wr_q.cnt - LO;
        wr_d.mem[waddr] = din;
        wr_d.cnt    = step(wr_q.cnt);
        wr_d.gry    = gray(wr_d.cnt);
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q.cnt <= WRST;
            wr_q.gry <= gray(WRST);
            wr_q.mem <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    // ---------------- read side (reference clock) ----------------
    always_comb begin
        rd_d      = rd_q;
        rd_d.cnt  = step(rd_q.cnt);
        rd_d.s1   = wr_q.gry;
        rd_d.s2   = rd_q.s1;
        rd_d.slip = rd_q.slip | (rd_q.s2 == gray(rd_q.cnt));
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q.cnt  <= LO;
            rd_q.s1   <= gray(WRST);
            rd_q.s2   <= gray(WRST);
            rd_q.slip <= 1'b0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign raddr = rd_q.cnt - LO;
    assign dout  = wr_q.mem[raddr];
    assign slip  = rd_q.slip;
    assign wsync = rd_q.s2;

endmodule

// File: rtl/ilm_prbs.sv
`timescale 1ns/1ps
module ilm_prbs #(
    parameter int BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [BITS-1:0] word
);
    typedef struct packed {
        logic [ilm_pkg::PRBS_W-1:0] st;
    } prbs_t;

    prbs_t p_d, p_q;

    always_comb begin
        logic [ilm_pkg::PRBS_W-1:0] s;
        s = p_q.st;
        for (int k = 0; k < BITS; k++) begin
            s = ilm_pkg::prbs_step(s);
            word[BITS-1-k] = s[0];
        end
        p_d.st = s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q.st <= ilm_pkg::PRBS_SEED;
        else        p_q    <= p_d;
    end

endmodule

// File: rtl/ilm_ser.sv
`timescale 1ns/1ps
module ilm_ser #(
    parameter  int W  = 4,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] par,
    output logic         ser,
    output logic         load
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  sr;
    } ser_t;

    ser_t s_d, s_q;

    assign load = (s_q.cnt == CW'(W - 1));

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + CW'(1);
        s_d.sr  = load ? par : {s_q.sr[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ser = s_q.sr[W-1];

endmodule

// File: rtl/lane_interleave_mux.sv
`timescale 1ns/1ps
module lane_interleave_mux #(
    parameter  int LANES = 4,
    parameter  int DEPTH = 10,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic             clk_ref,
    input  logic             clk_ser,
    input  logic             rst_n,
    input  logic             test_n,
    input  logic [LANES-1:0] lane_clk,
    input  logic [LANES-1:0] lane_dat,
    output logic [LANES-1:0] word_o,
    output logic             ser_o,
    output logic [LANES-1:0] slip_o
);
    typedef struct packed {
        logic [LANES-1:0] word;
    } top_t;

    top_t t_d, t_q;

    logic [LANES-1:0]         rd_bit;
    logic [LANES-1:0]         lane_word;
    logic [LANES-1:0]         prbs_word;
    logic [LANES-1:0][PW-1:0] wsync;
    logic                     ser_load;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ilm_estore #(.DEPTH(DEPTH)) u_es (
            .wclk  (lane_clk[g]),
            .rclk  (clk_ref),
            .rst_n (rst_n),
            .din   (lane_dat[g]),
            .dout  (rd_bit[g]),
            .slip  (slip_o[g]),
            .wsync (wsync[g])
        );
        // lane 0 lands in the most significant bit
        assign lane_word[LANES-1-g] = rd_bit[g];
    end

    ilm_prbs #(.BITS(LANES)) u_prbs (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .word  (prbs_word)
    );

    always_comb begin
        t_d      = t_q;
        t_d.word = test_n ? lane_word : prbs_word;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign word_o = t_q.word;

    ilm_ser #(.W(LANES)) u_ser (
        .clk   (clk_ser),
        .rst_n (rst_n),
        .par   (t_q.word),
        .ser   (ser_o),
        .load  (ser_load)
    );

endmodule

// File: rtl/ilm_chk.sv
`timescale 1ns/1ps
module ilm_chk #(
    parameter int LANES = 4,
    parameter int PW    = 4
) (
    input logic                     clk_ref,
    input logic                     clk_ser,
    input logic                     rst_n,
    input logic                     test_n,
    input logic [LANES-1:0]         word_o,
    input logic                     ser_o,
    input logic [LANES-1:0]         slip_o,
    input logic                     ser_load,
    input logic [LANES-1:0][PW-1:0] wsync
);
    // R1
    always @(posedge clk_ref) begin
        if (!rst_n) begin
            reset_state_chk: assert (word_o == '0 && slip_o == '0 && ser_o == 1'b0);
        end
    end

    // R7
    slip_sticky_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (|slip_o) |=> ((slip_o & $past(slip_o)) == $past(slip_o)));

    // R5
    load_spacing_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
        ser_load |=> !ser_load ##1 !ser_load ##1 !ser_load ##1 ser_load);

    // R6
    prbs_recur_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(rst_n, 2) && !$past(test_n) && !$past(test_n, 2))
        |-> (word_o[0] == ($past(word_o[3]) ^ $past(word_o[2]))));

    for (genvar k = 0; k < LANES; k++) begin : g_gray
        // R9
        gray_step_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
            $countones(wsync[k] ^ $past(wsync[k])) <= 1);
    end

endmodule

bind lane_interleave_mux ilm_chk #(.LANES(LANES), .PW(PW)) u_chk (.*);

// File: tb/test_lane_interleave_mux.sv
`timescale 1ns/1ps
module test_lane_interleave_mux;
    localparam int NB = 2048;

    logic       clk_ref = 1'b0;
    logic       clk_ser = 1'b0;
    logic       rst_n   = 1'b0;
    logic       test_n  = 1'b1;
    logic [3:0] lane_ph = '0;
    logic [3:0] lane_en = 4'hF;
    logic [3:0] lane_clk;
    logic [3:0] lane_dat = '0;
    logic [3:0] word_o;
    logic [3:0] slip_o;
    logic       ser_o;

    logic [3:0] lane_bits [NB];
    logic       test_hist [NB];
    logic [3:0] words     [NB];
    int         lane_j [4];
    int         errors = 0;
    int         checks = 0;
    bit         done   = 0;

    assign lane_clk = lane_ph & lane_en;

    lane_interleave_mux i_lane_interleave_mux (
        .clk_ref  (clk_ref),
        .clk_ser  (clk_ser),
        .rst_n    (rst_n),
        .test_n   (test_n),
        .lane_clk (lane_clk),
        .lane_dat (lane_dat),
        .word_o   (word_o),
        .ser_o    (ser_o),
        .slip_o   (slip_o)
    );

    always #5    clk_ref = ~clk_ref;
    always #1.25 clk_ser = ~clk_ser;

    for (genvar g = 0; g < 4; g++) begin : g_drv
        localparam int PH = (g == 0) ? 1 : (g == 1) ? 3 : (g == 2) ? 6 : 9;
        initial begin
            #(PH);
            forever #5 lane_ph[g] = ~lane_ph[g];
        end
        always @(posedge lane_clk[g]) begin
            if (rst_n) begin
                lane_j[g] = lane_j[g] + 1;
                #2 lane_dat[g] = lane_bits[lane_j[g] % NB][g];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] map_lanes(input logic [3:0] b);
        logic [3:0] w;
        for (int i = 0; i < 4; i++) w[3-i] = b[i];
        return w;
    endfunction

    function automatic logic prbs_ok(input logic [11:0] v);
        logic ok;
        ok = 1'b1;
        // v[11] is the earliest bit; element k is v[11-k]
        for (int k = 8; k < 12; k++)
            if (v[11-k] !== (v[11-(k-6)] ^ v[11-(k-7)])) ok = 1'b0;
        return ok;
    endfunction

    task automatic fill(input bit directed);
        for (int j = 0; j < NB; j++) begin
            if (directed && j < 16) lane_bits[j] = 4'b0001 << (j % 4);
            else if (directed && j < 24) lane_bits[j] = (j % 2 == 0) ? 4'hF : 4'h0;
            else lane_bits[j] = 4'($urandom);
        end
    endtask

    task automatic release_reset();
        for (int i = 0; i < 4; i++) begin
            lane_j[i]   = 0;
            lane_dat[i] = lane_bits[0][i];
        end
        @(negedge clk_ref);
        #0.5 rst_n = 1'b1;
    endtask

    task automatic run_phase(input int ncyc, input int tlo, input int thi);
        logic [3:0] w, ser;
        logic [3:0] exp;
        bit         nz;
        nz = 0;
        test_hist[0] = test_n;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk_ref);
            w = word_o;
            words[n] = w;
            test_n = !((n + 1) >= tlo && (n + 1) < thi);
            test_hist[n+1] = test_n;
            ser[3] = ser_o;
            #2.5 ser[2] = ser_o;
            #2.5 ser[1] = ser_o;
            #2.5 ser[0] = ser_o;
            if (test_hist[n]) begin
                if (n < 5) begin
                    chk($sformatf("R4 word n=%0d", n), 32'(w), 32'h0);
                end else begin
                    exp = map_lanes(lane_bits[n-5]);
                    chk($sformatf("R2/R3 word n=%0d", n), 32'(w), 32'(exp));
                end
            end else begin
                if (w != 4'h0) nz = 1;
                if (n >= 2 && !test_hist[n-1] && !test_hist[n-2])
                    chk($sformatf("R6 sequence n=%0d", n),
                        32'(prbs_ok({words[n-2], words[n-1], w})), 32'h1);
            end
            chk($sformatf("R5 serial n=%0d", n), 32'(ser), 32'(w));
        end
        if (tlo < thi) chk("R6 nonzero test words", 32'(nz), 32'h1);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        fill(1'b1);
        repeat (3) @(posedge clk_ref);
        @(negedge clk_ref);
        // R1
        chk("R1 word in reset", 32'(word_o), 32'h0);
        chk("R1 slip in reset", 32'(slip_o), 32'h0);
        chk("R1 serial in reset", 32'(ser_o), 32'h0);

        release_reset();
        run_phase(400, 150, 230);
        // R8: lanes running at reference rate never slip
        chk("R8 no slip in normal run", 32'(slip_o), 32'h0);

        // R7: stall lane 2 long enough for the read pointer to meet it
        @(negedge clk_ref);
        lane_en[2] = 1'b0;
        repeat (15) @(negedge clk_ref);
        lane_en[2] = 1'b1;
        repeat (3) @(negedge clk_ref);
        chk("R7 slip on stalled lane only", 32'(slip_o), 32'h4);
        repeat (10) @(negedge clk_ref);
        chk("R7 slip stays set", 32'(slip_o[2]), 32'h1);

        // R8: reset clears slip
        rst_n = 1'b0;
        repeat (2) @(negedge clk_ref);
        chk("R8 slip cleared by reset", 32'(slip_o), 32'h0);
        chk("R1 word cleared by reset", 32'(word_o), 32'h0);

        fill(1'b0);
        test_n = 1'b1;
        release_reset();
        run_phase(80, 30, 50);
        chk("R8 no slip after reset", 32'(slip_o), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule